// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block collects the interrupt sources aimed at an embedded processor into sixteen groups of 32 sources. Each group keeps a latched status word and an enable word. Its result word is the bitwise AND of the two, and it is formed on the fly rather than stored. The OR of a group's result bits is gated by that group's bit in a block-select word. The gated value drives one interrupt line per group. Line g serves processor interrupt number g.

A control bit can also route every result bit to its own line in a wide per-source vector. This lets the processor's interrupt controller take sources one by one instead of by group. When the bit is clear, that vector is held at zero.

Software reaches every register through a private single-cycle write port with a combinational read port. Status bits clear when 1 is written to them. Group g occupies the 20 bytes at address g*0x14. Block-select sits just past the last group and the control word follows it.

Top module: `irq_group_aggregator`

## Requirements
- R1: A source input that is high at a rising clock edge sets its status bit, read at group offset 0x0. The bit stays set after the source returns low.
- R2: Writing to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: When a source is high in the same cycle that software clears its status bit, the bit ends up set.
- R4: A read at group offset 0x8 returns status AND enable. Writes to that offset change nothing.
- R5: Output bit g of the group interrupt vector equals the OR of group g's result bits ANDed with bit g of the block-select word at 0x140.
- R6: When bit 0 of the control word at 0x144 is 1, bit g*32+b of the direct vector equals result bit b of group g. When it is 0, the whole direct vector is zero.
- R7: Reset clears every status, enable, block-select and control bit. Both output vectors are then zero.
- R8: The enable word at group offset 0x4, the block-select word and the control word read back what was last written. An enable word holds its value when it is not written.
- R9: Reads of an unmapped address, such as group offset 0xC or address 0x148, return zero. Writes to such an address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| src_i | input | 512 | Source events, bit g*32+b is source b of group g |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| grp_irq_o | output | 16 | Per-group aggregated interrupt lines |
| direct_irq_o | output | 512 | Per-source result lines, active with direct routing |

## Verification
The assertions assume that `src_i` changes only between clock edges and carries no unknown values once reset is released. They also assume that a register write lasts exactly one cycle with a stable address and data. The bench drives sources and the register port on the falling edge, so each value is settled a half period before the edge that samples it. It also holds sources at zero from time zero through reset, so the first post-reset comparisons never see stale inputs.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned GRP_STRIDE = 'h14;
  localparam int unsigned OFS_STATUS = 'h0;
  localparam int unsigned OFS_ENABLE = 'h4;
  localparam int unsigned OFS_RESULT = 'h8;

  // Byte address of the first register of group g.
  function automatic int unsigned grp_base(int unsigned g);
    return g * GRP_STRIDE;
  endfunction

  // Next status value: clear mask first, incoming events override it.
  function automatic logic [REG_W-1:0] stat_next(logic [REG_W-1:0] cur,
                                                 logic [REG_W-1:0] evt,
                                                 logic [REG_W-1:0] clr);
    return (cur & ~clr) | evt;
  endfunction

  function automatic logic [REG_W-1:0] masked(logic [REG_W-1:0] st,
                                              logic [REG_W-1:0] en);
    return st & en;
  endfunction

  typedef struct packed {
    logic clr_stat;
    logic wr_en;
  } grp_cmd_t;
endpackage

// File: rtl/irqagg_regdec.sv
module irqagg_regdec
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [NUM_GROUPS-1:0] hit_stat_o,
  output logic [NUM_GROUPS-1:0] hit_en_o,
  output logic [NUM_GROUPS-1:0] hit_res_o,
  output logic                  hit_bsel_o,
  output logic                  hit_ctrl_o
);
  localparam int unsigned BSEL_OFS = grp_base(NUM_GROUPS);
  localparam int unsigned CTRL_OFS = BSEL_OFS + 4;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign hit_stat_o[g] = (addr_i == ADDR_W'(grp_base(g) + OFS_STATUS));
    assign hit_en_o[g]   = (addr_i == ADDR_W'(grp_base(g) + OFS_ENABLE));
    assign hit_res_o[g]  = (addr_i == ADDR_W'(grp_base(g) + OFS_RESULT));
  end

  assign hit_bsel_o = (addr_i == ADDR_W'(BSEL_OFS));
  assign hit_ctrl_o = (addr_i == ADDR_W'(CTRL_OFS));
endmodule

// File: rtl/irqagg_group.sv
module irqagg_group
  import irqagg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src_i,
  input  grp_cmd_t         cmd_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             sel_i,
  input  logic             direct_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] enable_o,
  output logic [REG_W-1:0] result_o,
  output logic [REG_W-1:0] clr_mask_o,
  output logic             irq_o,
  output logic [REG_W-1:0] direct_o
);
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] enable_q;

  assign clr_mask_o = cmd_i.clr_stat ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= stat_next(status_q, src_i, clr_mask_o);
      if (cmd_i.wr_en) enable_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign result_o = masked(status_q, enable_q);
  assign irq_o    = (|result_o) & sel_i;
  assign direct_o = direct_i ? result_o : '0;
endmodule

// File: rtl/irqagg_rdmux.sv
module irqagg_rdmux
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16
) (
  input  logic [NUM_GROUPS-1:0]       hit_stat_i,
  input  logic [NUM_GROUPS-1:0]       hit_en_i,
  input  logic [NUM_GROUPS-1:0]       hit_res_i,
  input  logic                        hit_bsel_i,
  input  logic                        hit_ctrl_i,
  input  logic [NUM_GROUPS*REG_W-1:0] status_i,
  input  logic [NUM_GROUPS*REG_W-1:0] enable_i,
  input  logic [NUM_GROUPS*REG_W-1:0] result_i,
  input  logic [NUM_GROUPS-1:0]       bsel_i,
  input  logic                        ctrl_i,
  output logic [REG_W-1:0]            rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (hit_stat_i[g]) rdata_o = rdata_o | status_i[g*REG_W +: REG_W];
      if (hit_en_i[g])   rdata_o = rdata_o | enable_i[g*REG_W +: REG_W];
      if (hit_res_i[g])  rdata_o = rdata_o | result_i[g*REG_W +: REG_W];
    end
    if (hit_bsel_i) rdata_o = rdata_o | REG_W'(bsel_i);
    if (hit_ctrl_i) rdata_o = rdata_o | REG_W'(ctrl_i);
  end
endmodule

// File: rtl/irq_group_aggregator.sv
module irq_group_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_GROUPS*REG_W-1:0] src_i,
  input  logic                        reg_wr_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic [REG_W-1:0]            reg_wdata_i,
  output logic [REG_W-1:0]            reg_rdata_o,
  output logic [NUM_GROUPS-1:0]       grp_irq_o,
  output logic [NUM_GROUPS*REG_W-1:0] direct_irq_o
);
  localparam int unsigned FLAT_W = NUM_GROUPS * REG_W;

  logic [NUM_GROUPS-1:0] hit_stat, hit_en, hit_res;
  logic                  hit_bsel, hit_ctrl;
  logic [NUM_GROUPS-1:0] bsel_q;
  logic                  ctrl_q;

  // Named internal events for the checker.
  logic [FLAT_W-1:0]     status_flat, enable_flat, result_flat, clr_flat;
  logic [NUM_GROUPS-1:0] en_wr_vec;
  logic                  en_wr_any;

  irqagg_regdec #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i     (reg_addr_i),
    .hit_stat_o (hit_stat),
    .hit_en_o   (hit_en),
    .hit_res_o  (hit_res),
    .hit_bsel_o (hit_bsel),
    .hit_ctrl_o (hit_ctrl)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    grp_cmd_t cmd;
    assign cmd.clr_stat = reg_wr_i & hit_stat[g];
    assign cmd.wr_en    = reg_wr_i & hit_en[g];
    assign en_wr_vec[g] = cmd.wr_en;

    irqagg_group u_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i[g*REG_W +: REG_W]),
      .cmd_i      (cmd),
      .wdata_i    (reg_wdata_i),
      .sel_i      (bsel_q[g]),
      .direct_i   (ctrl_q),
      .status_o   (status_flat[g*REG_W +: REG_W]),
      .enable_o   (enable_flat[g*REG_W +: REG_W]),
      .result_o   (result_flat[g*REG_W +: REG_W]),
      .clr_mask_o (clr_flat[g*REG_W +: REG_W]),
      .irq_o      (grp_irq_o[g]),
      .direct_o   (direct_irq_o[g*REG_W +: REG_W])
    );
  end

  assign en_wr_any = |en_wr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsel_q <= '0;
      ctrl_q <= 1'b0;
    end else if (reg_wr_i) begin
      if (hit_bsel) bsel_q <= reg_wdata_i[NUM_GROUPS-1:0];
      if (hit_ctrl) ctrl_q <= reg_wdata_i[0];
    end
  end

  irqagg_rdmux #(.NUM_GROUPS(NUM_GROUPS)) u_rd (
    .hit_stat_i (hit_stat),
    .hit_en_i   (hit_en),
    .hit_res_i  (hit_res),
    .hit_bsel_i (hit_bsel),
    .hit_ctrl_i (hit_ctrl),
    .status_i   (status_flat),
    .enable_i   (enable_flat),
    .result_i   (result_flat),
    .bsel_i     (bsel_q),
    .ctrl_i     (ctrl_q),
    .rdata_o    (reg_rdata_o)
  );
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_GROUPS*REG_W-1:0] src_i,
  input logic [NUM_GROUPS*REG_W-1:0] status_flat,
  input logic [NUM_GROUPS*REG_W-1:0] enable_flat,
  input logic [NUM_GROUPS*REG_W-1:0] clr_flat,
  input logic                        en_wr_any,
  input logic [NUM_GROUPS-1:0]       bsel_q,
  input logic                        ctrl_q,
  input logic [NUM_GROUPS-1:0]       grp_irq_o,
  input logic [NUM_GROUPS*REG_W-1:0] direct_irq_o
);
  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != '0) |=> ((status_flat & $past(src_i)) == $past(src_i))); // R1

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_flat & src_i) != '0) |=> ((status_flat & $past(clr_flat & src_i)) != '0)); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flat != '0) |=> ((status_flat & $past(clr_flat & ~src_i)) == '0)); // R2

  AST_GROUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_irq_o & ~bsel_q) == '0)); // R5

  AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q |-> (direct_irq_o == '0)); // R6

  AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q |-> (direct_irq_o == (status_flat & enable_flat))); // R6

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_any |=> $stable(enable_flat)); // R8
endmodule

bind irq_group_aggregator irqagg_checker #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_i        (src_i),
  .status_flat  (status_flat),
  .enable_flat  (enable_flat),
  .clr_flat     (clr_flat),
  .en_wr_any    (en_wr_any),
  .bsel_q       (bsel_q),
  .ctrl_q       (ctrl_q),
  .grp_irq_o    (grp_irq_o),
  .direct_irq_o (direct_irq_o)
);

// File: tb/irq_group_aggregator_tb.sv
module irq_group_aggregator_tb;
  localparam int NG   = 16;
  localparam int W    = 32;
  localparam int AW   = 12;
  localparam int CLKP = 20;
  localparam int BSEL = NG * 'h14;
  localparam int CTRL = BSEL + 4;

  typedef struct packed {
    logic [3:0]  g;
    logic [31:0] src;
    logic [31:0] en;
    logic        sel;
    logic        dir;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0,  32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, 1'b1},
    '{4'd3,  32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0},
    '{4'd5,  32'h0000_00F0, 32'h0000_0010, 1'b0, 1'b1, 1'b0},
    '{4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1},
    '{4'd7,  32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0},
    '{4'd9,  32'h0101_0000, 32'h0001_0000, 1'b1, 1'b1, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NG*W-1:0] src = '0;
  logic            wr = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [W-1:0]    wdata = '0;
  logic [W-1:0]    rdata;
  logic [NG-1:0]   grp_irq;
  logic [NG*W-1:0] direct;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLKP/2) clk = ~clk;

  irq_group_aggregator #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_dut (
    .clk (clk), .rst_n (rst_n), .src_i (src), .reg_wr_i (wr),
    .reg_addr_i (addr), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
    .grp_irq_o (grp_irq), .direct_irq_o (direct)
  );

  function automatic logic [AW-1:0] a_of(int g, int ofs);
    return AW'(g * 'h14 + ofs);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [AW-1:0] a, logic [W-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [AW-1:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(int g, logic [W-1:0] p);
    @(negedge clk); src = '0; src[g*W +: W] = p;
    @(negedge clk); src = '0;
  endtask

  initial begin
    #(CLKP * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 grp_irq", W'(grp_irq), '0);
    chk("R7 direct", W'(|direct), '0);
    rreg(a_of(4, 0), r); chk("R7 status", r, '0);
    rreg(a_of(4, 4), r); chk("R7 enable", r, '0);
    rreg(AW'(BSEL), r);  chk("R7 bsel", r, '0);
    rreg(AW'(CTRL), r);  chk("R7 ctrl", r, '0);
    rst_n = 1'b1;

    // Table walk: R1 R4 R5 R6
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      logic [W-1:0] res = v.src & v.en;
      wreg(AW'(CTRL), W'(v.dir));
      wreg(AW'(BSEL), W'(NG'(v.sel) << v.g));
      wreg(a_of(v.g, 4), v.en);
      wreg(a_of(v.g, 0), 32'hFFFF_FFFF);
      pulse(v.g, v.src);
      rreg(a_of(v.g, 0), r); chk("R1 status latched", r, v.src);
      rreg(a_of(v.g, 8), r); chk("R4 result", r, res);
      chk("R5 group line", W'(grp_irq), v.exp ? W'(NG'(1) << v.g) : '0);
      chk("R6 direct slice", direct[v.g*W +: W], v.dir ? res : '0);
    end

    // R2 write-one-to-clear
    wreg(AW'(CTRL), 32'h0);
    wreg(a_of(2, 4), 32'hFFFF_FFFF);
    pulse(2, 32'h0000_00F0);
    wreg(a_of(2, 0), 32'h0000_0010);
    rreg(a_of(2, 0), r); chk("R2 clear one bit", r, 32'h0000_00E0);
    wreg(a_of(2, 0), 32'h0);
    rreg(a_of(2, 0), r); chk("R2 zero write no effect", r, 32'h0000_00E0);

    // R3 set wins over same-cycle clear
    @(negedge clk); src = '0; src[2*W] = 1'b1;
    wr = 1'b1; addr = a_of(2, 0); wdata = 32'h0000_0001;
    @(negedge clk); wr = 1'b0; src = '0;
    rreg(a_of(2, 0), r); chk("R3 set wins", r, 32'h0000_00E1);

    // R4 result is read-only
    wreg(a_of(2, 8), 32'h0);
    rreg(a_of(2, 8), r); chk("R4 result write ignored", r, 32'h0000_00E1);

    // R5 gating by block-select, then enable masking
    wreg(AW'(BSEL), 32'h0000_0004);
    chk("R5 selected group", W'(grp_irq), 32'h0000_0004);
    wreg(a_of(2, 4), 32'h0000_0100);
    chk("R5 masked group", W'(grp_irq), 32'h0);

    // R8 readback
    rreg(a_of(2, 4), r); chk("R8 enable readback", r, 32'h0000_0100);
    rreg(AW'(BSEL), r);  chk("R8 bsel readback", r, 32'h0000_0004);
    wreg(AW'(CTRL), 32'h1);
    rreg(AW'(CTRL), r);  chk("R8 ctrl readback", r, 32'h1);
    chk("R6 direct bit", W'(direct[2*W +: W]), 32'h0);

    // R9 unmapped addresses
    wreg(a_of(2, 'hC), 32'hFFFF_FFFF);
    wreg(AW'(CTRL + 4), 32'hFFFF_FFFF);
    rreg(a_of(2, 'hC), r); chk("R9 gap reads zero", r, '0);
    rreg(AW'(CTRL + 4), r); chk("R9 past end reads zero", r, '0);
    rreg(a_of(2, 0), r); chk("R9 status untouched", r, 32'h0000_00E1);
    rreg(a_of(2, 4), r); chk("R9 enable untouched", r, 32'h0000_0100);
    rreg(AW'(BSEL), r);  chk("R9 bsel untouched", r, 32'h0000_0004);

    // R7 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    rreg(a_of(2, 0), r); chk("R7 status after reset", r, '0);
    rreg(AW'(CTRL), r);  chk("R7 ctrl after reset", r, '0);
    chk("R7 direct after reset", W'(|direct), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule